// File: doc/BRIEF.md
# Parallel Exhaustive AES-128 Key Search Engine

The engine recovers an unknown AES-128 key from one known plaintext block and the ciphertext that key produces. After a start strobe it captures both 128-bit blocks and walks the key space upward from zero. Several identical encryption lanes each try a different candidate key. Lane `i` tries `base + i`, and `base` grows by the lane count after every pass. Each lane runs one AES round per clock with the round key built on the fly. A pass therefore lasts a fixed 11 cycles: one load cycle and ten rounds.

At the end of every pass each lane compares its ciphertext with the captured target. If any lane matches, the lowest matching key is latched, a found flag rises, and the elapsed-cycle counter freezes. If the pass that holds the all-ones key of the search width ends without a match, a not-found flag rises and the search stops. The search width is a parameter. By default it is the full 128 bits, and a narrower width keeps the upper key bits at zero.

Top module: `keysrch_engine`

## Requirements
- R1: After reset `busy`, `found` and `not_found` are 0 and `elapsed` and `found_key` are all zero.
- R2: A `start` pulse seen while `busy` is 0 makes `busy` 1 on the next cycle, clears `found` and `not_found`, and sets `elapsed` to 0.
- R3: Each lane computes standard AES-128 encryption. For a plaintext whose sixteen bytes are all 0x30 and the target 3c57908a5d398d62c5954fe48051e3cd, the search returns key 0x…03.
- R4: Candidate keys are tried in ascending order from zero, `LANES` per pass, with lane `i` on key `base+i`. When a match occurs, `found_key` is the key whose encryption equals the target. Bits of the key at and above the search width are zero.
- R5: `elapsed` rises by one on every cycle while `busy` is 1. A pass takes 11 cycles, so a key first tried in pass `p` (counting from 0) is reported with `elapsed` = 11·(p+1).
- R6: `found` and `not_found` are never 1 together or while `busy` is 1. `busy` falls on the same edge at which a result flag rises. The flag, `found_key` and `elapsed` then hold until the next `start`.
- R7: `plaintext` and `ciphertext` are sampled only at the accepted `start`. Changes to them during a search, and further `start` pulses during a search, have no effect on the result or on `elapsed`.
- R8: If no key in 0 … 2^SEARCH_BITS−1 matches, `not_found` rises after the pass that contains the all-ones key. With 3 lanes and a 3-bit width this happens at `elapsed` = 33.
- R9: A `start` after a finished search begins a fresh search from key zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a search when idle |
| plaintext | input | 128 | Known plaintext block |
| ciphertext | input | 128 | Target ciphertext block |
| busy | output | 1 | Search in progress |
| found | output | 1 | A matching key was latched |
| not_found | output | 1 | The key range was exhausted without a match |
| found_key | output | 128 | Recovered key |
| elapsed | output | CNT_W | Cycles spent on the last search |

## Verification
The properties assume that `start` is a pulse the host may raise at any time. They also assume that the target blocks are stable for the cycle in which `start` is accepted. The stimulus drives every input at the falling edge, holds `start` high for exactly one cycle, and deliberately changes both blocks and pulses `start` again in the middle of a search. Expected keys come from an independent reference cipher inside the bench, anchored by the fixed all-0x30 vector. A narrow-width instance drives the key counter past its top so that exhaustion can be observed.

// File: rtl/keysrch_pkg.sv
package keysrch_pkg;
  localparam int BLK_W  = 128;
  localparam int ROUNDS = 10;
  localparam int PASS   = ROUNDS + 1;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h00;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ p;
      p = xt(p);
    end
    return r;
  endfunction

  // a^254 equals the multiplicative inverse (and maps 0 to 0)
  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] p;
    r = 8'h01;
    p = a;
    for (int i = 1; i < 8; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] subst(input logic [7:0] a);
    logic [7:0] v;
    v = ginv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [31:0] mixcol(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = c;
    return {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
            xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
  endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import keysrch_pkg::*;
(
  input  logic [7:0] a,
  output logic [7:0] y
);
  always_comb y = subst(a);
endmodule

// File: rtl/aes_lane.sv
module aes_lane
  import keysrch_pkg::*;
(
  input  logic             clk,
  input  logic             load,
  input  logic             last,
  input  logic [7:0]       rcon,
  input  logic [BLK_W-1:0] pt,
  input  logic [BLK_W-1:0] key,
  output logic [BLK_W-1:0] nxt
);
  localparam int NB = BLK_W / 8;

  logic [BLK_W-1:0] st, rk, sb, sr, mc, rk_n;
  logic [31:0]      kw_sub;
  logic [31:0]      rot_w;

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_sb
      aes_sbox u_sb (.a(st[BLK_W-1-8*g -: 8]), .y(sb[BLK_W-1-8*g -: 8]));
    end
    for (g = 0; g < 4; g++) begin : g_ks
      aes_sbox u_ks (.a(rot_w[31-8*g -: 8]), .y(kw_sub[31-8*g -: 8]));
    end
  endgenerate

  assign rot_w = {rk[23:0], rk[31:24]};

  always_comb begin
    logic [31:0] t;
    t = kw_sub ^ {rcon, 24'h0};
    rk_n[127:96] = rk[127:96] ^ t;
    rk_n[95:64]  = rk[95:64] ^ rk_n[127:96];
    rk_n[63:32]  = rk[63:32] ^ rk_n[95:64];
    rk_n[31:0]   = rk[31:0]  ^ rk_n[63:32];
  end

  always_comb begin
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        sr[BLK_W-1-8*(r+4*c) -: 8] = sb[BLK_W-1-8*(r+4*((c+r)%4)) -: 8];
    for (int c = 0; c < 4; c++)
      mc[BLK_W-1-32*c -: 32] = mixcol(sr[BLK_W-1-32*c -: 32]);
    nxt = (last ? sr : mc) ^ rk_n;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      st <= pt ^ key;
      rk <= key;
    end else begin
      st <= nxt;
      rk <= rk_n;
    end
  end
endmodule

// File: rtl/match_pick.sv
module match_pick #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic [N-1:0]  hit,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |hit;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (hit[i]) idx = IW'(i);
  end
endmodule

// File: rtl/keysrch_engine.sv
module keysrch_engine
  import keysrch_pkg::*;
#(
  parameter int LANES       = 3,
  parameter int SEARCH_BITS = 128,
  parameter int CNT_W       = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [127:0]     plaintext,
  input  logic [127:0]     ciphertext,
  output logic             busy,
  output logic             found,
  output logic             not_found,
  output logic [127:0]     found_key,
  output logic [CNT_W-1:0] elapsed
);
  localparam int SW = SEARCH_BITS;
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [SW:0]      base;
  logic [SW:0]      base_n;
  logic [3:0]       rnd;
  logic [7:0]       rcon;
  logic [BLK_W-1:0] pt_q, ct_q;
  logic [BLK_W-1:0] cand  [LANES];
  logic [BLK_W-1:0] ct_l  [LANES];
  logic [LANES-1:0] hit;
  logic             any;
  logic [IW-1:0]    idx;
  logic             load, last;

  assign load   = busy && (rnd == 4'd0);
  assign last   = (rnd == 4'(ROUNDS));
  assign base_n = base + (SW+1)'(LANES);

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      logic [SW:0] ksum;
      assign ksum    = base + (SW+1)'(i);
      assign cand[i] = BLK_W'(ksum[SW-1:0]);
      assign hit[i]  = (ct_l[i] == ct_q) && !ksum[SW];
      aes_lane u_lane (
        .clk (clk), .load(load), .last(last), .rcon(rcon),
        .pt  (pt_q), .key(cand[i]), .nxt(ct_l[i])
      );
    end
  endgenerate

  match_pick #(.N(LANES), .IW(IW)) u_pick (.hit(hit), .any(any), .idx(idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; found <= 1'b0; not_found <= 1'b0;
      found_key <= '0; elapsed <= '0;
      base <= '0; rnd <= '0; rcon <= 8'h01;
      pt_q <= '0; ct_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1; found <= 1'b0; not_found <= 1'b0;
        found_key <= '0; elapsed <= '0;
        base <= '0; rnd <= '0;
        pt_q <= plaintext; ct_q <= ciphertext;
      end
    end else begin
      elapsed <= elapsed + 1'b1;
      rcon    <= (rnd == 4'd0) ? 8'h01 : xt(rcon);
      if (last) begin
        rnd <= '0;
        if (any) begin
          found     <= 1'b1;
          found_key <= cand[idx];
          busy      <= 1'b0;
        end else if (base_n[SW]) begin
          not_found <= 1'b1;
          busy      <= 1'b0;
        end else begin
          base <= base_n;
        end
      end else begin
        rnd <= rnd + 4'd1;
      end
    end
  end
endmodule

// File: rtl/keysrch_checker.sv
module keysrch_checker #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             found,
  input logic             not_found,
  input logic [127:0]     found_key,
  input logic [CNT_W-1:0] elapsed
);
  assert_excl_flags_R6: assert property (@(posedge clk) disable iff (rst)
    !(found && not_found));
  assert_busy_no_flag_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!found && !not_found));
  assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && elapsed == '0 && !found && !not_found));
  assert_tick_R5: assert property (@(posedge clk) disable iff (rst)
    busy |=> (elapsed == $past(elapsed) + 1'b1));
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(elapsed) && $stable(found_key) && $stable(found) && $stable(not_found)));
  assert_pass_len_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(found) |-> ((elapsed % 11) == 0));
endmodule

bind keysrch_engine keysrch_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .found(found),
  .not_found(not_found), .found_key(found_key), .elapsed(elapsed)
);

// File: tb/keysrch_engine_bench.sv
module keysrch_engine_bench;
  localparam int CW = 48;

  typedef struct packed {
    logic [127:0] pt;
    logic [7:0]   key;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{128'h00112233445566778899aabbccddeeff, 8'd0},
    '{128'h0,                                8'd1},
    '{{16{8'hff}},                           8'd2},
    '{128'h0123456789abcdeffedcba9876543210, 8'd4},
    '{{16{8'h30}},                           8'd5},
    '{128'hdeadbeefcafef00d0badc0de12345678, 8'd8}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, start2 = 1'b0;
  logic [127:0] pt = '0, ct = '0, pt2 = '0, ct2 = '0;
  logic busy, found, nf, busy2, found2, nf2;
  logic [127:0] fkey, fkey2;
  logic [CW-1:0] el, el2;
  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  keysrch_engine #(.LANES(3), .SEARCH_BITS(128), .CNT_W(CW)) u_keysrch_engine (
    .clk(clk), .rst(rst), .start(start), .plaintext(pt), .ciphertext(ct),
    .busy(busy), .found(found), .not_found(nf), .found_key(fkey), .elapsed(el));

  keysrch_engine #(.LANES(3), .SEARCH_BITS(3), .CNT_W(CW)) u_small (
    .clk(clk), .rst(rst), .start(start2), .plaintext(pt2), .ciphertext(ct2),
    .busy(busy2), .found(found2), .not_found(nf2), .found_key(fkey2), .elapsed(el2));

  // independent reference cipher
  function automatic logic [7:0] rmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] rsbox(input logic [7:0] a);
    logic [7:0] v = 0;
    logic [7:0] s;
    for (int y = 1; y < 256; y++)
      if (rmul(a, 8'(y)) == 8'h01) v = 8'(y);
    s = 8'h63;
    for (int k = 0; k < 5; k++)
      s ^= (v << k) | (v >> (8 - k));
    return s;
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] p, input logic [127:0] k);
    logic [7:0] s[16], w[16], t[16], tmp[4];
    logic [7:0] rc = 8'h01;
    logic [127:0] o;
    for (int i = 0; i < 16; i++) begin
      w[i] = k[127-8*i -: 8];
      s[i] = p[127-8*i -: 8] ^ w[i];
    end
    for (int r = 1; r <= 10; r++) begin
      tmp[0] = rsbox(w[13]) ^ rc; tmp[1] = rsbox(w[14]);
      tmp[2] = rsbox(w[15]);      tmp[3] = rsbox(w[12]);
      for (int j = 0; j < 4; j++) w[j] ^= tmp[j];
      for (int j = 4; j < 16; j++) w[j] ^= w[j-4];
      rc = rmul(rc, 8'h02);
      for (int c = 0; c < 4; c++)
        for (int q = 0; q < 4; q++)
          t[q+4*c] = rsbox(s[q+4*((c+q)%4)]);
      for (int c = 0; c < 4; c++) begin
        if (r < 10) begin
          s[4*c]   = rmul(t[4*c],2) ^ rmul(t[4*c+1],3) ^ t[4*c+2] ^ t[4*c+3];
          s[4*c+1] = t[4*c] ^ rmul(t[4*c+1],2) ^ rmul(t[4*c+2],3) ^ t[4*c+3];
          s[4*c+2] = t[4*c] ^ t[4*c+1] ^ rmul(t[4*c+2],2) ^ rmul(t[4*c+3],3);
          s[4*c+3] = rmul(t[4*c],3) ^ t[4*c+1] ^ t[4*c+2] ^ rmul(t[4*c+3],2);
        end else begin
          for (int q = 0; q < 4; q++) s[4*c+q] = t[4*c+q];
        end
      end
      for (int i = 0; i < 16; i++) s[i] ^= w[i];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic launch(input logic [127:0] p, input logic [127:0] c);
    @(negedge clk);
    pt = p; ct = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !found && !nf && el == 0, "R2 launch", {busy, found, nf}, 3'b100);
  endtask

  task automatic wait_done();
    for (int n = 0; n < 400 && !(found || nf); n++) @(negedge clk);
  endtask

  task automatic expect_key(input logic [127:0] k, input string tag);
    int exp_el;
    exp_el = 11 * (int'(k) / 3 + 1);
    wait_done();
    chk(found && !nf && !busy, {tag, " R6 found flag"}, {busy, found, nf}, 3'b010);
    chk(fkey == k, {tag, " R4 key"}, fkey, k);
    chk(el == CW'(exp_el), {tag, " R5 elapsed"}, 128'(el), 128'(exp_el));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !found && !nf && fkey == 0 && el == 0, "R1 reset", {busy, found, nf}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R3 fixed vector
    launch({16{8'h30}}, 128'h3c57908a5d398d62c5954fe48051e3cd);
    expect_key(128'd3, "R3");

    // R4 / R9 table walk, each run restarts from zero
    foreach (VEC[v]) begin
      launch(VEC[v].pt, ref_enc(VEC[v].pt, 128'(VEC[v].key)));
      expect_key(128'(VEC[v].key), "R4 R9 table");
    end

    // R6 result holds
    repeat (7) @(negedge clk);
    chk(found && fkey == 128'd8 && el == 33, "R6 hold", fkey, 128'd8);

    // R7 inputs and start ignored mid-search
    launch(128'h55, ref_enc(128'h55, 128'd4));
    repeat (4) @(negedge clk);
    pt = 128'h99; ct = ref_enc(128'h99, 128'd1); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expect_key(128'd4, "R7");

    // R8 exhaustion on narrow instance
    @(negedge clk);
    pt2 = {16{8'h30}}; ct2 = 128'h0; start2 = 1'b1;
    @(negedge clk);
    start2 = 1'b0;
    for (int n = 0; n < 100 && !(found2 || nf2); n++) @(negedge clk);
    chk(nf2 && !found2 && !busy2, "R8 not_found", {busy2, found2, nf2}, 3'b001);
    chk(el2 == 33, "R8 elapsed", 128'(el2), 128'd33);

    // R4 narrow instance finds top key 7 after exhaustion run
    pt2 = 128'h77; ct2 = ref_enc(128'h77, 128'd7); start2 = 1'b1;
    @(negedge clk);
    start2 = 1'b0;
    for (int n = 0; n < 100 && !(found2 || nf2); n++) @(negedge clk);
    chk(found2 && !nf2 && fkey2 == 128'd7, "R4 R9 narrow key", fkey2, 128'd7);
    chk(el2 == 33, "R5 narrow elapsed", 128'(el2), 128'd33);

    finish_run();
  end
endmodule